// File: doc/BRIEF.md
# Configuration access address router

This block turns CPU configuration requests into register accesses. Each request names a bus, device, function and register offset. For bus 0, the block forwards the access to the root port's own configuration registers. For any other bus, it first loads a setup register with the target bus, device, function and request type. It then forwards the access through a remote window that sits above the local space. The downstream side is a plain request/response port with an error flag.

Only one access is in flight at a time. The CPU side sees `cpu_ready_o` drop when a request is accepted and gets a one-cycle `cpu_rsp_o` once the downstream answer has come back. A read that ends in an error returns all ones, so a missing device looks like an empty slot rather than a fault. A write that ends in an error is acknowledged as if nothing happened. Byte and halfword reads are taken from the lane that the register offset's two low bits select.

Top module: `cfg_route`

## Requirements
- R1: A request on bus 0 goes to downstream address equal to the register offset with bits 1:0 cleared (local space) and leaves `setup_o` unchanged.
- R2: A request on any bus other than 0 goes to downstream address 0x1000 plus the register offset with bits 1:0 cleared (remote window).
- R3: For a remote request, `setup_o` holds the bus number in bits 23:16, the device number in bits 12:8 and the function number in bits 2:0. All other bits are zero except bit 24.
- R4: Bit 24 of `setup_o` (type 1 select) is set for bus numbers 2 and above and clear for bus 1.
- R5: For a remote request, `setup_o` already holds the new value in the cycle in which `dn_req_o` is raised. `dn_req_o` is a single-cycle pulse, issued exactly once per access, and `setup_o` holds steady while the access is outstanding.
- R6: `cpu_ready_o` is low from acceptance until the response. `cpu_rsp_o` stays low until `dn_rsp_i` arrives, then pulses for one cycle in the cycle after `dn_rsp_i`. The block is ready again in the cycle after that.
- R7: A read whose downstream response carries `dn_err_i` returns data derived from 0xFFFFFFFF in place of `dn_rdata_i`.
- R8: Reads request all four byte lanes. The returned data is the downstream dword shifted right by 8 times offset[1:0], then zero-extended to the access size. Size code 0 is a byte, 1 is a halfword and 2 is a word.
- R9: Writes drive byte enables of 0x1 for a byte, 0x3 for a halfword or 0xF for a word, each shifted left by offset[1:0]. The write data is shifted left by 8 times offset[1:0].
- R10: A write completes with a normal `cpu_rsp_o` and `cpu_rdata_o` of zero, whether or not `dn_err_i` is set.
- R11: After reset, `cpu_ready_o` is 1, `dn_req_o` and `cpu_rsp_o` are 0, and `setup_o` is 0.

Bus numbers are 8 bits wide, device numbers 5 bits and function numbers 3 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | Request strobe, taken when `cpu_ready_o` is high |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_bus_i | input | 8 | Target bus number |
| cpu_dev_i | input | 5 | Target device number |
| cpu_fn_i | input | 3 | Target function number |
| cpu_reg_i | input | 12 | Register byte offset |
| cpu_size_i | input | 2 | 0 byte, 1 halfword, 2 word |
| cpu_wdata_i | input | 32 | Right-aligned write data |
| cpu_ready_o | output | 1 | Idle, able to take a request |
| cpu_rsp_o | output | 1 | One-cycle completion pulse |
| cpu_rdata_o | output | 32 | Right-aligned read data, valid with `cpu_rsp_o` |
| dn_req_o | output | 1 | One-cycle downstream request |
| dn_we_o | output | 1 | Downstream write flag |
| dn_addr_o | output | 13 | Dword-aligned downstream address |
| dn_be_o | output | 4 | Byte enables |
| dn_wdata_o | output | 32 | Lane-aligned write data |
| dn_rsp_i | input | 1 | Downstream response strobe |
| dn_rdata_i | input | 32 | Downstream read data |
| dn_err_i | input | 1 | Downstream error flag |
| setup_o | output | 32 | Setup register for remote accesses |

## Verification
Accesses on bus 0, bus 1, mid-range buses and bus 255 show apart the three routes: local, remote type 0 and remote type 1. A bus-0 access placed after a remote one shows whether the local path leaves the setup register alone. Byte, halfword and word reads at every lane offset, with and without an error response, separate the lane shift, the size mask and the all-ones substitution. Write patterns with a long response delay and with an error response expose byte-enable placement, the CPU-side stall and the silent drop of write errors.

// File: rtl/cfg_route_pkg.sv
package cfg_route_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_ISSUE, ST_WAIT, ST_DONE
  } cfg_st_e;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
endpackage

// File: rtl/cfg_setup_reg.sv
module cfg_setup_reg #(
  parameter int BUS_W   = 8,
  parameter int DEV_W   = 5,
  parameter int FN_W    = 3,
  parameter int SETUP_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [BUS_W-1:0]   bus_i,
  input  logic [DEV_W-1:0]   dev_i,
  input  logic [FN_W-1:0]    fn_i,
  output logic [SETUP_W-1:0] setup_o
);
  localparam int BUS_LSB  = 16;
  localparam int DEV_LSB  = 8;
  localparam int TYPE_BIT = 24;

  logic [SETUP_W-1:0] nxt;

  always_comb begin
    nxt = '0;
    nxt[BUS_LSB +: BUS_W] = bus_i;
    nxt[DEV_LSB +: DEV_W] = dev_i;
    nxt[0 +: FN_W]        = fn_i;
    nxt[TYPE_BIT]         = (bus_i > BUS_W'(1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     setup_o <= '0;
    else if (load_i) setup_o <= nxt;
  end
endmodule

// File: rtl/cfg_lane_unit.sv
module cfg_lane_unit
  import cfg_route_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFS_W = $clog2(LANES)
) (
  input  logic [OFS_W-1:0]  ofs_i,
  input  logic [1:0]        size_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic              err_i,
  output logic [LANES-1:0]  be_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [DATA_W-1:0] rdata_o
);
  int                nbytes;
  logic [DATA_W-1:0] masked;
  logic [DATA_W-1:0] shifted;

  always_comb begin
    case (size_i)
      SZ_BYTE: nbytes = 1;
      SZ_HALF: nbytes = 2;
      default: nbytes = LANES;
    endcase
  end

  // missing target reads as all ones before lane pick
  assign masked  = err_i ? '1 : rdata_i;
  assign shifted = masked >> {ofs_i, 3'b000};
  assign wdata_o = wdata_i << {ofs_i, 3'b000};

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign be_o[k] = (k >= int'(ofs_i)) && (k < int'(ofs_i) + nbytes);
    assign rdata_o[8*k +: 8] = (k < nbytes) ? shifted[8*k +: 8] : 8'h00;
  end
endmodule

// File: rtl/cfg_route.sv
module cfg_route
  import cfg_route_pkg::*;
#(
  parameter int               BUS_W    = 8,
  parameter int               DEV_W    = 5,
  parameter int               FN_W     = 3,
  parameter int               REG_W    = 12,
  parameter int               ADDR_W   = 13,
  parameter int               DATA_W   = 32,
  parameter logic [ADDR_W-1:0] WIN_BASE = 13'h1000,
  localparam int              LANES    = DATA_W / 8,
  localparam int              OFS_W    = $clog2(LANES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [BUS_W-1:0]  cpu_bus_i,
  input  logic [DEV_W-1:0]  cpu_dev_i,
  input  logic [FN_W-1:0]   cpu_fn_i,
  input  logic [REG_W-1:0]  cpu_reg_i,
  input  logic [1:0]        cpu_size_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              cpu_ready_o,
  output logic              cpu_rsp_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              dn_req_o,
  output logic              dn_we_o,
  output logic [ADDR_W-1:0] dn_addr_o,
  output logic [LANES-1:0]  dn_be_o,
  output logic [DATA_W-1:0] dn_wdata_o,
  input  logic              dn_rsp_i,
  input  logic [DATA_W-1:0] dn_rdata_i,
  input  logic              dn_err_i,
  output logic [31:0]       setup_o
);
  cfg_st_e           st_q, st_d;
  logic              we_q;
  logic [BUS_W-1:0]  bus_q;
  logic [DEV_W-1:0]  dev_q;
  logic [FN_W-1:0]   fn_q;
  logic [REG_W-1:0]  reg_q;
  logic [1:0]        size_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              accept;
  logic              remote;
  logic [ADDR_W-1:0] dword_ofs;
  logic [LANES-1:0]  lane_be;
  logic [DATA_W-1:0] lane_rdata;

  assign accept = cpu_req_i && (st_q == ST_IDLE);
  assign remote = (bus_q != '0);

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:  if (cpu_req_i) st_d = (cpu_bus_i == '0) ? ST_ISSUE : ST_SETUP;
      ST_SETUP: st_d = ST_ISSUE;
      ST_ISSUE: st_d = ST_WAIT;
      ST_WAIT:  if (dn_rsp_i) st_d = ST_DONE;
      ST_DONE:  st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      we_q    <= 1'b0;
      bus_q   <= '0;
      dev_q   <= '0;
      fn_q    <= '0;
      reg_q   <= '0;
      size_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        we_q    <= cpu_we_i;
        bus_q   <= cpu_bus_i;
        dev_q   <= cpu_dev_i;
        fn_q    <= cpu_fn_i;
        reg_q   <= cpu_reg_i;
        size_q  <= cpu_size_i;
        wdata_q <= cpu_wdata_i;
      end
      // write errors dropped: writes always return zero data
      if (st_q == ST_WAIT && dn_rsp_i)
        rdata_q <= we_q ? '0 : lane_rdata;
    end
  end

  cfg_setup_reg #(
    .BUS_W(BUS_W), .DEV_W(DEV_W), .FN_W(FN_W), .SETUP_W(32)
  ) u_setup (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (st_q == ST_SETUP),
    .bus_i   (bus_q),
    .dev_i   (dev_q),
    .fn_i    (fn_q),
    .setup_o (setup_o)
  );

  cfg_lane_unit #(.DATA_W(DATA_W)) u_lane (
    .ofs_i   (reg_q[OFS_W-1:0]),
    .size_i  (size_q),
    .wdata_i (wdata_q),
    .rdata_i (dn_rdata_i),
    .err_i   (dn_err_i),
    .be_o    (lane_be),
    .wdata_o (dn_wdata_o),
    .rdata_o (lane_rdata)
  );

  assign dword_ofs   = ADDR_W'({reg_q[REG_W-1:OFS_W], {OFS_W{1'b0}}});
  assign dn_addr_o   = remote ? (WIN_BASE + dword_ofs) : dword_ofs;
  assign dn_req_o    = (st_q == ST_ISSUE);
  assign dn_we_o     = we_q;
  assign dn_be_o     = we_q ? lane_be : '1;
  assign cpu_ready_o = (st_q == ST_IDLE);
  assign cpu_rsp_o   = (st_q == ST_DONE);
  assign cpu_rdata_o = rdata_q;
endmodule

// File: rtl/cfg_route_chk.sv
module cfg_route_chk #(
  parameter int BUS_W  = 8,
  parameter int ADDR_W = 13,
  parameter int LANES  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cpu_req_i,
  input logic              cpu_ready_o,
  input logic [BUS_W-1:0]  cpu_bus_i,
  input logic              cpu_rsp_o,
  input logic              dn_req_o,
  input logic              dn_we_o,
  input logic [ADDR_W-1:0] dn_addr_o,
  input logic [LANES-1:0]  dn_be_o,
  input logic [31:0]       setup_o
);
  localparam int TYPE_BIT = 24;

  // R1
  bus0_setup_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_req_i && cpu_ready_o && cpu_bus_i == '0) |=> $stable(setup_o));

  // R4
  type1_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_req_i && cpu_ready_o && cpu_bus_i > BUS_W'(1)) |=> ##1 setup_o[TYPE_BIT]);

  // R4
  type0_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_req_i && cpu_ready_o && cpu_bus_i == BUS_W'(1)) |=> ##1 !setup_o[TYPE_BIT]);

  // R2
  dword_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_req_o |-> ((dn_addr_o & ADDR_W'(3)) == '0));

  // R5
  req_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_req_o |=> !dn_req_o);

  // R5
  setup_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_req_o |=> $stable(setup_o));

  // R6
  busy_on_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_req_o |-> !cpu_ready_o);

  // R6
  rsp_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_rsp_o |=> (!cpu_rsp_o && cpu_ready_o));

  // R8
  read_all_lanes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dn_req_o && !dn_we_o) |-> (dn_be_o == '1));
endmodule

bind cfg_route cfg_route_chk #(
  .BUS_W(BUS_W), .ADDR_W(ADDR_W), .LANES(LANES)
) u_chk (.*);

// File: tb/cfg_route_test.sv
`timescale 1ns/1ps
module cfg_route_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cpu_req_i = 1'b0;
  logic        cpu_we_i = 1'b0;
  logic [7:0]  cpu_bus_i = '0;
  logic [4:0]  cpu_dev_i = '0;
  logic [2:0]  cpu_fn_i = '0;
  logic [11:0] cpu_reg_i = '0;
  logic [1:0]  cpu_size_i = '0;
  logic [31:0] cpu_wdata_i = '0;
  logic        cpu_ready_o, cpu_rsp_o;
  logic [31:0] cpu_rdata_o;
  logic        dn_req_o, dn_we_o;
  logic [12:0] dn_addr_o;
  logic [3:0]  dn_be_o;
  logic [31:0] dn_wdata_o;
  logic        dn_rsp_i = 1'b0;
  logic [31:0] dn_rdata_i = '0;
  logic        dn_err_i = 1'b0;
  logic [31:0] setup_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] exp_setup = '0;

  always #2.5 clk_i = ~clk_i;

  cfg_route uut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic access(input logic [7:0] bus, input logic [4:0] dev,
                        input logic [2:0] fn, input logic [11:0] rg,
                        input logic [1:0] sz, input bit we,
                        input logic [31:0] wd, input logic [31:0] rsp,
                        input bit err, input int dly);
    logic [12:0] e_addr;
    logic [3:0]  e_be;
    logic [31:0] e_wd, e_rd, d;
    int n;
    e_addr = {1'b0, rg[11:2], 2'b00};
    if (bus != 0) begin
      e_addr = e_addr + 13'h1000;
      exp_setup = {7'd0, bus > 8'd1, bus, 3'd0, dev, 5'd0, fn};
    end
    case (sz)
      2'd0: e_be = 4'h1 << rg[1:0];
      2'd1: e_be = 4'h3 << rg[1:0];
      default: e_be = 4'hF;
    endcase
    if (!we) e_be = 4'hF;
    e_wd = wd << (8 * rg[1:0]);
    d = err ? 32'hFFFF_FFFF : rsp;
    d = d >> (8 * rg[1:0]);
    case (sz)
      2'd0: e_rd = d & 32'hFF;
      2'd1: e_rd = d & 32'hFFFF;
      default: e_rd = d;
    endcase
    if (we) e_rd = '0;

    @(negedge clk_i);
    cpu_req_i = 1'b1; cpu_we_i = we; cpu_bus_i = bus; cpu_dev_i = dev;
    cpu_fn_i = fn; cpu_reg_i = rg; cpu_size_i = sz; cpu_wdata_i = wd;
    @(negedge clk_i);
    cpu_req_i = 1'b0;
    n = 0;
    while (!dn_req_o && n < 20) begin
      @(negedge clk_i);
      n++;
    end
    chk(dn_req_o, "R5 request issued", 32'(dn_req_o), 32'd1);
    chk(dn_addr_o == e_addr, bus == 0 ? "R1 local addr" : "R2 window addr",
        32'(dn_addr_o), 32'(e_addr));
    chk(setup_o == exp_setup, bus == 0 ? "R1 setup untouched" : "R3/R4 setup value",
        setup_o, exp_setup);
    chk(dn_be_o == e_be, we ? "R9 write be" : "R8 read be", 32'(dn_be_o), 32'(e_be));
    chk(dn_we_o == we, "R9 we", 32'(dn_we_o), 32'(we));
    if (we) chk(dn_wdata_o == e_wd, "R9 wdata", dn_wdata_o, e_wd);
    for (int i = 0; i < dly; i++) begin
      @(negedge clk_i);
      if (i == 0) chk(!dn_req_o, "R5 single pulse", 32'(dn_req_o), 32'd0);
      chk(!cpu_rsp_o && !cpu_ready_o, "R6 stall", 32'({cpu_rsp_o, cpu_ready_o}), 32'd0);
    end
    chk(setup_o == exp_setup, "R5 setup held", setup_o, exp_setup);
    dn_rsp_i = 1'b1; dn_rdata_i = rsp; dn_err_i = err;
    @(negedge clk_i);
    dn_rsp_i = 1'b0; dn_rdata_i = '0; dn_err_i = 1'b0;
    chk(cpu_rsp_o, "R6 response pulse", 32'(cpu_rsp_o), 32'd1);
    chk(cpu_rdata_o == e_rd,
        we ? "R10 write ack data" : (err ? "R7 error read" : "R8 read data"),
        cpu_rdata_o, e_rd);
    @(negedge clk_i);
    chk(!cpu_rsp_o && cpu_ready_o, "R6 back to idle",
        32'({cpu_rsp_o, cpu_ready_o}), 32'b01);
  endtask

  task automatic t_reset;
    @(negedge clk_i);
    chk(cpu_ready_o && !dn_req_o && !cpu_rsp_o, "R11 reset outputs",
        32'({cpu_ready_o, dn_req_o, cpu_rsp_o}), 32'b100);
    chk(setup_o == 32'h0, "R11 reset setup", setup_o, 32'h0);
  endtask

  task automatic t_local;
    access(8'd0, 5'd0, 3'd0, 12'h010, 2'd2, 1'b0, '0, 32'h1234_5678, 1'b0, 1); // R1
    access(8'd0, 5'd2, 3'd1, 12'h013, 2'd0, 1'b0, '0, 32'h1234_5678, 1'b0, 2); // R1 R8
  endtask

  task automatic t_remote;
    access(8'd1, 5'd3, 3'd2, 12'h100, 2'd2, 1'b0, '0, 32'hCAFE_0001, 1'b0, 1);   // R2 R4
    access(8'd5, 5'd31, 3'd7, 12'hFFC, 2'd2, 1'b0, '0, 32'h0BAD_F00D, 1'b0, 3);  // R3 R4
    access(8'd0, 5'd1, 3'd1, 12'h004, 2'd2, 1'b0, '0, 32'h0000_0042, 1'b0, 1);   // R1 after remote
    access(8'd255, 5'd16, 3'd4, 12'h040, 2'd2, 1'b0, '0, 32'h8765_4321, 1'b0, 1); // R4
    access(8'd2, 5'd0, 3'd0, 12'h000, 2'd2, 1'b0, '0, 32'h1111_2222, 1'b0, 1);   // R4 boundary
    access(8'd1, 5'd9, 3'd5, 12'h00C, 2'd2, 1'b0, '0, 32'h3333_4444, 1'b0, 1);   // R4 back to type 0
  endtask

  task automatic t_lanes;
    for (int o = 0; o < 4; o++)
      access(8'd1, 5'd1, 3'd0, 12'h020 + 12'(o), 2'd0, 1'b0, '0, 32'hAABB_CCDD, 1'b0, 1); // R8
    access(8'd3, 5'd1, 3'd0, 12'h022, 2'd1, 1'b0, '0, 32'hAABB_CCDD, 1'b0, 1); // R8 half hi
    access(8'd3, 5'd1, 3'd0, 12'h020, 2'd1, 1'b0, '0, 32'hAABB_CCDD, 1'b0, 1); // R8 half lo
  endtask

  task automatic t_errors;
    access(8'd4, 5'd7, 3'd0, 12'h000, 2'd2, 1'b0, '0, 32'h0000_1234, 1'b1, 1); // R7 word
    access(8'd4, 5'd7, 3'd0, 12'h002, 2'd1, 1'b0, '0, 32'h0000_1234, 1'b1, 1); // R7 half
    access(8'd0, 5'd0, 3'd0, 12'h001, 2'd0, 1'b0, '0, 32'h0000_0000, 1'b1, 1); // R7 byte local
  endtask

  task automatic t_writes;
    access(8'd1, 5'd2, 3'd3, 12'h033, 2'd0, 1'b1, 32'h0000_005A, '0, 1'b0, 1); // R9 byte
    access(8'd6, 5'd2, 3'd3, 12'h036, 2'd1, 1'b1, 32'h0000_BEEF, '0, 1'b0, 1); // R9 half
    access(8'd0, 5'd0, 3'd0, 12'h018, 2'd2, 1'b1, 32'hDEAD_BEEF, '0, 1'b0, 30); // R9 R6 long stall
    access(8'd7, 5'd4, 3'd1, 12'h010, 2'd2, 1'b1, 32'h0102_0304, 32'hFFFF_0000, 1'b1, 2); // R10
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_local();
    t_remote();
    t_lanes();
    t_errors();
    t_writes();
    repeat (2) @(negedge clk_i);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd1, 32'd0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule